// File: doc/BRIEF.md
# Threshold-Gated Write Request Controller

This block decides when a bus master asks for the bus to move data out of a local write FIFO. For ordinary writes of known length the request goes up as soon as the FIFO holds any data. For packet writes, the source gives no length and may stall mid-packet. In that case the request waits until the FIFO holds a programmable number of dwords, unless the FIFO is already full or the source has flagged the end of the packet.

Once a write burst is under way, the FIFO may run dry before the end-of-transaction flag is seen. The controller then drops the request and pulses a terminate signal for one cycle, and data already queued stays in the FIFO. It then waits for the end-of-transaction flag and, if data is still queued, opens a new transaction to carry the rest. A burst that drains the FIFO while the flag is set simply completes, with no terminate pulse.

Top module: `wr_req_ctrl`

## Requirements
- R1: After reset, `bus_req` and `term_now` are both 0.
- R2: With `pkt_mode` = 0 and no write open, a nonzero `fifo_level` raises `bus_req` on the next clock edge.
- R3: With `pkt_mode` = 1 and `thresh` > 0, `bus_req` stays 0 while 0 < `fifo_level` < `thresh`, `eot` = 0 and the FIFO is not full. It rises on the edge after `fifo_level` reaches `thresh`.
- R4: With `pkt_mode` = 1 and `thresh` = 0, the start behaves as in R2.
- R5: In packet mode, a `fifo_level` equal to `DEPTH` raises `bus_req` on the next edge, even when `thresh` exceeds `DEPTH`.
- R6: In packet mode, `eot` = 1 with a nonzero `fifo_level` below the threshold raises `bus_req` on the next edge.
- R7: While `bus_req` = 1, a `fifo_level` of 0 with `eot` = 0 makes the next edge clear `bus_req` and set `term_now` for exactly one cycle.
- R8: While `bus_req` = 1, a `fifo_level` of 0 with `eot` = 1 in the same cycle ends the write. `bus_req` clears on the next edge and `term_now` stays 0.
- R9: After a starvation termination, `bus_req` stays 0 until `eot` = 1 with a nonzero `fifo_level`. In that case it rises on the next edge, whatever the threshold.
- R10: After a starvation termination, `eot` = 1 with `fifo_level` = 0 returns the controller to idle without a request. A later start then obeys the threshold again.
- R11: `term_now` is never high on two consecutive cycles. It is only high in a cycle whose previous cycle had `bus_req` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LVL_W | Dwords currently held in the write FIFO |
| pkt_mode | input | 1 | 1 = packet write of unknown length, 0 = known-length write |
| thresh | input | LVL_W | Fill threshold in dwords for packet mode |
| eot | input | 1 | Source has signalled end of transaction |
| bus_req | output | 1 | Bus request for the write transaction |
| term_now | output | 1 | One-cycle pulse: end the current transaction because the FIFO starved |

## Verification
The FIFO can drain to empty in the same cycle that the source raises the end-of-transaction flag. The controller must then treat the write as complete rather than starved. The bench drives a zero level together with `eot` high while a burst is open, and expects the request to drop with no terminate pulse. A separate pass drives the zero level with `eot` low, and expects the pulse and then the restart only after the flag arrives.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_BURST   = 2'd1,
        PH_STARVED = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   req;
        logic   term;
    } seq_state_t;
endpackage

// File: rtl/wrq_start_gate.sv
module wrq_start_gate #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] thresh,
    input  logic             pkt_mode,
    input  logic             eot,
    output logic             start_ok,
    output logic             empty
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic has_data;
    logic at_full;
    logic at_thresh;
    logic no_gate;

    always_comb begin
        has_data  = (fifo_level != '0);
        empty     = !has_data;
        at_full   = (fifo_level >= FULL_LVL);
        at_thresh = (fifo_level >= thresh);
        no_gate   = !pkt_mode || (thresh == '0);
        start_ok  = has_data && (no_gate || at_thresh || at_full || eot);
    end
endmodule

// File: rtl/wrq_seq.sv
module wrq_seq
    import wrq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic empty,
    input  logic eot,
    output logic req,
    output logic term
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.term = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_ok) begin
                    st_d.phase = PH_BURST;
                    st_d.req   = 1'b1;
                end
            end
            PH_BURST: begin
                if (empty) begin
                    st_d.req   = 1'b0;
                    st_d.term  = !eot;
                    st_d.phase = eot ? PH_IDLE : PH_STARVED;
                end
            end
            PH_STARVED: begin
                if (eot) begin
                    st_d.phase = empty ? PH_IDLE : PH_BURST;
                    st_d.req   = !empty;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.req   <= 1'b0;
            st_q.term  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = st_q.req;
    assign term = st_q.term;

    // R2
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && start_ok) |=> req);

    // R7
    starve_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && empty && !eot) |=> (term && !req));

    // R8
    clean_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && empty && eot) |=> (!term && !req));

    // R9
    starved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STARVED && !eot) |=> !req);

    // R11
    term_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> !term);

    // R11
    term_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term) |-> $past(req));
endmodule

// File: rtl/wr_req_ctrl.sv
module wr_req_ctrl #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             pkt_mode,
    input  logic [LVL_W-1:0] thresh,
    input  logic             eot,
    output logic             bus_req,
    output logic             term_now
);
    logic start_ok;
    logic empty;

    wrq_start_gate #(.DEPTH(DEPTH), .LVL_W(LVL_W)) gate_i (
        .fifo_level (fifo_level),
        .thresh     (thresh),
        .pkt_mode   (pkt_mode),
        .eot        (eot),
        .start_ok   (start_ok),
        .empty      (empty)
    );

    wrq_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .empty    (empty),
        .eot      (eot),
        .req      (bus_req),
        .term     (term_now)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !term_now));

    // R3
    below_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !term_now && pkt_mode && thresh != '0 && !eot
         && fifo_level < thresh && fifo_level < LVL_W'(DEPTH)
         && $past(!bus_req) && !$past(term_now) && $past(rst_n))
        |=> !bus_req);
endmodule

// File: tb/wr_req_ctrl_tb_top.sv
module wr_req_ctrl_tb_top;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             pkt_mode = 1'b0;
    logic [LVL_W-1:0] thresh = '0;
    logic             eot = 1'b0;
    logic             bus_req;
    logic             term_now;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // behavioural reference: 0 idle, 1 writing, 2 starved
    int m_mode = 0;
    bit m_req = 0;
    bit m_term = 0;

    always #5 clk = ~clk;

    wr_req_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .pkt_mode(pkt_mode),
        .thresh(thresh), .eot(eot), .bus_req(bus_req), .term_now(term_now)
    );

    always @(posedge clk) begin
        int lvl;
        int thr;
        bit go;
        lvl = int'(fifo_level);
        thr = int'(thresh);
        m_term = 0;
        if (!rst_n) begin
            m_mode = 0;
            m_req  = 0;
        end else if (m_mode == 0) begin
            go = 0;
            if (lvl > 0) begin
                if (!pkt_mode || thr == 0) go = 1;
                else if (lvl >= thr || lvl >= DEPTH || eot) go = 1;
            end
            if (go) begin m_mode = 1; m_req = 1; end
        end else if (m_mode == 1) begin
            if (lvl == 0) begin
                m_req = 0;
                if (eot) m_mode = 0;
                else begin m_mode = 2; m_term = 1; end
            end
        end else begin
            if (eot) begin
                if (lvl > 0) begin m_mode = 1; m_req = 1; end
                else m_mode = 0;
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            checks++;
            if (bus_req !== m_req || term_now !== m_term) begin
                errors++;
                $display("FAIL %s model: req=%b term=%b expected req=%b term=%b",
                         cur_tag, bus_req, term_now, m_req, m_term);
            end
        end
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int l, input bit e);
        @(negedge clk);
        #1;
        fifo_level = LVL_W'(l);
        eot = e;
    endtask

    task automatic chk(input string tag, input bit exp_req, input bit exp_term);
        @(posedge clk);
        #2;
        checks++;
        if (bus_req !== exp_req || term_now !== exp_term) begin
            errors++;
            $display("FAIL %s: req=%b term=%b expected req=%b term=%b",
                     tag, bus_req, term_now, exp_req, exp_term);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (bus_req !== 1'b0 || term_now !== 1'b0) begin
            errors++;
            $display("FAIL R1: req=%b term=%b expected req=0 term=0", bus_req, term_now);
        end
        @(negedge clk); #1; rst_n = 1'b1;

        // R2 known-length start, then R8 clean end
        cur_tag = "R2"; pkt_mode = 0; thresh = 5'd8;
        cyc(0, 0); chk("R2", 0, 0);
        cyc(1, 0); chk("R2", 1, 0);
        cyc(2, 0); chk("R2", 1, 0);
        cur_tag = "R8";
        cyc(0, 1); chk("R8", 0, 0);
        cyc(0, 0); chk("R8", 0, 0);

        // R3 threshold gating, R7 starvation, R9 restart
        cur_tag = "R3"; pkt_mode = 1; thresh = 5'd8;
        cyc(3, 0); chk("R3", 0, 0);
        cyc(7, 0); chk("R3", 0, 0);
        cyc(8, 0); chk("R3", 1, 0);
        cyc(4, 0); chk("R3", 1, 0);
        cur_tag = "R7";
        cyc(0, 0); chk("R7", 0, 1);
        cyc(0, 0); chk("R11", 0, 0);
        cur_tag = "R9";
        cyc(3, 0); chk("R9", 0, 0);
        cyc(5, 1); chk("R9", 1, 0);
        cur_tag = "R8";
        cyc(0, 1); chk("R8", 0, 0);
        cyc(0, 0); chk("R8", 0, 0);

        // R4 zero threshold
        cur_tag = "R4"; thresh = 5'd0;
        cyc(1, 0); chk("R4", 1, 0);
        cyc(0, 1); chk("R4", 0, 0);
        cyc(0, 0);

        // R5 full overrides threshold above depth
        cur_tag = "R5"; thresh = 5'd20;
        cyc(10, 0); chk("R5", 0, 0);
        cyc(16, 0); chk("R5", 1, 0);
        cyc(0, 1); chk("R5", 0, 0);
        cyc(0, 0);

        // R6 eot below threshold
        cur_tag = "R6"; thresh = 5'd8;
        cyc(2, 1); chk("R6", 1, 0);
        cyc(0, 1); chk("R6", 0, 0);
        cyc(0, 0);

        // R10 starved then eot with empty FIFO
        cur_tag = "R10";
        cyc(8, 0); chk("R10", 1, 0);
        cyc(0, 0); chk("R10", 0, 1);
        cyc(0, 1); chk("R10", 0, 0);
        cyc(0, 0); chk("R10", 0, 0);
        cyc(3, 0); chk("R10", 0, 0);
        cyc(8, 0); chk("R10", 1, 0);
        cyc(0, 1); chk("R10", 0, 0);
        cyc(0, 0);
        repeat (3) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule